// File: doc/BRIEF.md
# Interrupt Source Mode and Pending Tracker

This block keeps, for each of a parameterised number of wired interrupt sources (numbered from 1; number 0 is reserved), a configuration word, a pending bit, an enable bit and the last sampled input level. Each source is programmed into one of a small set of trigger modes. The mode decides which hardware input events and which software set or clear requests may change the pending bit. A delegated source holds only a flag and a 10-bit child index, and all of its state is held quiet.

Software reaches the block through a single-cycle write port. An operation code selects one of three kinds of request: a configuration write to a source, a set or clear of pending or enable by source number, or a set of pending by a source number whose bytes arrive swapped. The tracker exposes four vectors: pending, enable, a rectified input level, and pending-and-enabled, which is the ready vector. A combinational probe returns the stored configuration word of any source. A build parameter selects direct or message delivery, because the two handle software requests on level-triggered sources differently.

Top module: `irqsrc_tracker`

## Requirements
- R1: After reset every pending, enable, level and ready bit is 0 and every configuration word reads back as 0.
- R2: Operation code 0 writes the configuration of source `wr_src_i`. If data bit 10 is set, the stored word is bit 10 plus data bits 9:0 (the child index), with mode 0. Otherwise the stored word is data bits 2:0 (the mode) alone. Mode codes: 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low, and 2 or 3 act as off.
- R3: When `NUM_CHILD` is 0, a configuration write with bit 10 set stores the all-zero word.
- R4: A configuration write that leaves a source delegated or with an all-zero word clears that source's pending and enable bits at the same clock edge. While a source is delegated, both bits stay 0.
- R5: In rising-edge mode, pending is set when the input is 1 and the sample from the previous cycle was 0. Falling-edge mode sets pending on the opposite transition. A software clear in the same cycle as an edge wins.
- R6: In level-high mode, pending is set in any cycle in which the input is 1. Level-low mode does the same when the input is 0.
- R7: For off, reserved and delegated sources, input events and software set or clear of pending have no effect. A detached source ignores its input but accepts software requests.
- R8: For level modes, software clear of pending is always ignored. Software set of pending is ignored with direct delivery (`MSG_MODE`=0) and accepted with message delivery.
- R9: Operation codes 3 and 4 set or clear the enable bit of source number `wr_data_i`. Neither has any effect on off, reserved or delegated sources.
- R10: Operation codes 1 and 2 set or clear pending of source number `wr_data_i`. For any by-number request, a number of 0 or greater than `NUM_SRC` has no effect.
- R11: Operation code 5 reverses the byte order of `wr_data_i` and then acts as a set of pending by that number. Codes 6 and 7 do nothing.
- R12: `lvl_o` shows the last sampled input for modes 4 and 6, shows it inverted for modes 5 and 7, and shows 0 otherwise. `ready_o` is the pending bit ANDed with the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Synchronous interrupt inputs, bit s is source s |
| wr_en_i | input | 1 | Write request valid for one cycle |
| wr_op_i | input | 3 | Operation code |
| wr_src_i | input | SRC_W | Source addressed by a configuration write |
| wr_data_i | input | 32 | Configuration word or source number |
| probe_src_i | input | SRC_W | Source whose configuration is shown on probe_cfg_o |
| pend_o | output | NUM_SRC | Pending bits |
| en_o | output | NUM_SRC | Enable bits |
| lvl_o | output | NUM_SRC | Rectified sampled input level |
| ready_o | output | NUM_SRC | Pending and enabled |
| probe_cfg_o | output | 32 | Stored configuration word of probe_src_i, 0 for source 0 |

## Verification
A write or input value presented in one cycle shows up on `pend_o`, `en_o`, `ready_o` and `lvl_o` just after the next rising edge. `probe_cfg_o` is combinational on the stored configuration, so it changes at that same edge. The bench changes inputs 2 ns after each rising edge and reads every output 2 ns after the following one. It advances its reference state once per edge, so each comparison lines up with exactly one register stage. Edge detection compares against the previous sample, so directed cases hold an input for a cycle before they toggle it.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

   localparam int CFG_W     = 32;
   localparam int CHILD_W   = 10;
   localparam int DELEG_BIT = 10;

   localparam logic [2:0] MODE_OFF    = 3'd0;
   localparam logic [2:0] MODE_DETACH = 3'd1;
   localparam logic [2:0] MODE_RISE   = 3'd4;
   localparam logic [2:0] MODE_FALL   = 3'd5;
   localparam logic [2:0] MODE_HIGH   = 3'd6;
   localparam logic [2:0] MODE_LOW    = 3'd7;

   typedef enum logic [2:0] {
      OP_CFG      = 3'd0,
      OP_SETP     = 3'd1,
      OP_CLRP     = 3'd2,
      OP_SETE     = 3'd3,
      OP_CLRE     = 3'd4,
      OP_SETP_SWP = 3'd5,
      OP_RSV6     = 3'd6,
      OP_RSV7     = 3'd7
   } wr_op_e;

   typedef struct packed {
      logic               deleg;
      logic [CHILD_W-1:0] child;
      logic [2:0]         mode;
   } src_cfg_t;

   function automatic logic mode_live(input src_cfg_t c);
      return !c.deleg && (c.mode == MODE_DETACH || c.mode[2]);
   endfunction

   function automatic logic mode_level(input src_cfg_t c);
      return !c.deleg && (c.mode == MODE_HIGH || c.mode == MODE_LOW);
   endfunction

   function automatic logic rectify(input src_cfg_t c, input logic smp);
      logic r;
      r = 1'b0;
      if (!c.deleg) begin
         case (c.mode)
            MODE_RISE, MODE_HIGH: r = smp;
            MODE_FALL, MODE_LOW:  r = !smp;
            default:              r = 1'b0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [CFG_W-1:0] cfg_word(input src_cfg_t c);
      return {{(CFG_W-CHILD_W-1){1'b0}}, c.deleg, c.child | {{(CHILD_W-3){1'b0}}, c.mode}};
   endfunction

   function automatic logic [31:0] swap_bytes(input logic [31:0] d);
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

endpackage

// File: rtl/irqsrc_wr_decode.sv
module irqsrc_wr_decode
   import irqsrc_pkg::*;
#(
   parameter int NUM_SRC   = 31,
   parameter int NUM_CHILD = 4,
   parameter int SRC_W     = 5
) (
   input  logic               wr_en_i,
   input  logic [2:0]         wr_op_i,
   input  logic [SRC_W-1:0]   wr_src_i,
   input  logic [31:0]        wr_data_i,
   output logic [NUM_SRC:1]   cfg_hit_o,
   output logic [NUM_SRC:1]   setp_o,
   output logic [NUM_SRC:1]   clrp_o,
   output logic [NUM_SRC:1]   sete_o,
   output logic [NUM_SRC:1]   clre_o,
   output src_cfg_t           cfg_new_o
);

   wr_op_e      op;
   logic [31:0] num;
   logic        is_cfg, is_setp, is_clrp, is_sete, is_clre;

   assign op      = wr_op_e'(wr_op_i);
   assign num     = (op == OP_SETP_SWP) ? swap_bytes(wr_data_i) : wr_data_i;
   assign is_cfg  = wr_en_i && (op == OP_CFG);
   assign is_setp = wr_en_i && (op == OP_SETP || op == OP_SETP_SWP);
   assign is_clrp = wr_en_i && (op == OP_CLRP);
   assign is_sete = wr_en_i && (op == OP_SETE);
   assign is_clre = wr_en_i && (op == OP_CLRE);

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_hit
      logic num_match;
      assign num_match    = (num == 32'(s));
      assign cfg_hit_o[s] = is_cfg  && (wr_src_i == SRC_W'(s));
      assign setp_o[s]    = is_setp && num_match;
      assign clrp_o[s]    = is_clrp && num_match;
      assign sete_o[s]    = is_sete && num_match;
      assign clre_o[s]    = is_clre && num_match;
   end

   if (NUM_CHILD == 0) begin : g_no_child
      always_comb begin
         cfg_new_o = '0;
         if (!wr_data_i[DELEG_BIT]) cfg_new_o.mode = wr_data_i[2:0];
      end
   end else begin : g_child
      always_comb begin
         cfg_new_o = '0;
         if (wr_data_i[DELEG_BIT]) begin
            cfg_new_o.deleg = 1'b1;
            cfg_new_o.child = wr_data_i[CHILD_W-1:0];
         end else begin
            cfg_new_o.mode = wr_data_i[2:0];
         end
      end
   end

endmodule

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
   import irqsrc_pkg::*;
#(
   parameter bit MSG_MODE = 1'b0
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     irq_i,
   input  logic     cfg_hit_i,
   input  src_cfg_t cfg_new_i,
   input  logic     setp_i,
   input  logic     clrp_i,
   input  logic     sete_i,
   input  logic     clre_i,
   output logic     pend_o,
   output logic     en_o,
   output logic     lvl_o,
   output src_cfg_t cfg_o
);

   src_cfg_t cfg_q;
   logic     pend_q, en_q, smp_q;
   logic     live, lvl_mode, hw_set, set_ok, clr_ok, kill;
   logic     pend_nx, en_nx;

   assign live     = mode_live(cfg_q);
   assign lvl_mode = mode_level(cfg_q);
   assign set_ok   = live && !(lvl_mode && !MSG_MODE);
   assign clr_ok   = live && !lvl_mode;
   assign kill     = cfg_hit_i && (cfg_new_i.deleg || cfg_new_i == '0);

   always_comb begin
      hw_set = 1'b0;
      if (!cfg_q.deleg) begin
         case (cfg_q.mode)
            MODE_RISE: hw_set = irq_i && !smp_q;
            MODE_FALL: hw_set = !irq_i && smp_q;
            MODE_HIGH: hw_set = irq_i;
            MODE_LOW:  hw_set = !irq_i;
            default:   hw_set = 1'b0;
         endcase
      end
   end

   always_comb begin
      pend_nx = pend_q | hw_set | (setp_i && set_ok);
      if (clrp_i && clr_ok) pend_nx = 1'b0;
      en_nx = en_q;
      if (sete_i && live) en_nx = 1'b1;
      if (clre_i && live) en_nx = 1'b0;
      if (kill) begin
         pend_nx = 1'b0;
         en_nx   = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         pend_q <= 1'b0;
         en_q   <= 1'b0;
         smp_q  <= 1'b0;
      end else begin
         if (cfg_hit_i) cfg_q <= cfg_new_i;
         pend_q <= pend_nx;
         en_q   <= en_nx;
         smp_q  <= irq_i;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign lvl_o  = rectify(cfg_q, smp_q);
   assign cfg_o  = cfg_q;

   assert_deleg_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q.deleg |-> (!pend_q && !en_q));

   assert_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(pend_q) && $past(!cfg_q.deleg && cfg_q.mode == MODE_RISE) && !$past(setp_i))
      |-> $past(irq_i && !smp_q));

   assert_level_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_hit_i && !cfg_q.deleg && cfg_q.mode == MODE_HIGH && irq_i) |=> pend_q);

   assert_dead_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_hit_i && !live && !pend_q) |=> !pend_q);

   assert_en_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_hit_i && !live) |=> $stable(en_q));

endmodule

// File: rtl/irqsrc_tracker.sv
module irqsrc_tracker
   import irqsrc_pkg::*;
#(
   parameter int NUM_SRC   = 31,
   parameter int NUM_CHILD = 4,
   parameter bit MSG_MODE  = 1'b0,
   localparam int SRC_W    = $clog2(NUM_SRC + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC:1]   irq_i,
   input  logic               wr_en_i,
   input  logic [2:0]         wr_op_i,
   input  logic [SRC_W-1:0]   wr_src_i,
   input  logic [31:0]        wr_data_i,
   input  logic [SRC_W-1:0]   probe_src_i,
   output logic [NUM_SRC:1]   pend_o,
   output logic [NUM_SRC:1]   en_o,
   output logic [NUM_SRC:1]   lvl_o,
   output logic [NUM_SRC:1]   ready_o,
   output logic [CFG_W-1:0]   probe_cfg_o
);

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_src
      $error("irqsrc_tracker: NUM_SRC must lie in 1..1023");
   end
   if (NUM_CHILD < 0 || NUM_CHILD > 1024) begin : g_bad_child
      $error("irqsrc_tracker: NUM_CHILD must lie in 0..1024");
   end

   logic [NUM_SRC:1] cfg_hit, setp, clrp, sete, clre;
   src_cfg_t         cfg_new;
   src_cfg_t         cfg_arr [NUM_SRC:1];

   irqsrc_wr_decode #(
      .NUM_SRC   (NUM_SRC),
      .NUM_CHILD (NUM_CHILD),
      .SRC_W     (SRC_W)
   ) u_dec (
      .wr_en_i   (wr_en_i),
      .wr_op_i   (wr_op_i),
      .wr_src_i  (wr_src_i),
      .wr_data_i (wr_data_i),
      .cfg_hit_o (cfg_hit),
      .setp_o    (setp),
      .clrp_o    (clrp),
      .sete_o    (sete),
      .clre_o    (clre),
      .cfg_new_o (cfg_new)
   );

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_slot
      irqsrc_slot #(
         .MSG_MODE (MSG_MODE)
      ) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .irq_i     (irq_i[s]),
         .cfg_hit_i (cfg_hit[s]),
         .cfg_new_i (cfg_new),
         .setp_i    (setp[s]),
         .clrp_i    (clrp[s]),
         .sete_i    (sete[s]),
         .clre_i    (clre[s]),
         .pend_o    (pend_o[s]),
         .en_o      (en_o[s]),
         .lvl_o     (lvl_o[s]),
         .cfg_o     (cfg_arr[s])
      );
   end

   assign ready_o = pend_o & en_o;

   always_comb begin
      probe_cfg_o = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (probe_src_i == SRC_W'(s)) probe_cfg_o = cfg_word(cfg_arr[s]);
      end
   end

endmodule

// File: tb/irqsrc_tracker_tb_top.sv
module irqsrc_tracker_tb_top;

   localparam int NS  = 31;
   localparam int NSB = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NS:1]  irq = '0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_op = '0;
   logic [4:0]   wr_src = '0;
   logic [31:0]  wr_data = '0;
   logic [4:0]   probe_src = '0;
   logic [NS:1]  pend, en, lvl, ready;
   logic [31:0]  probe_cfg;

   logic [NSB:1] b_irq = '0;
   logic         b_wr_en = 1'b0;
   logic [2:0]   b_wr_op = '0;
   logic [2:0]   b_wr_src = '0;
   logic [31:0]  b_wr_data = '0;
   logic [2:0]   b_probe_src = '0;
   logic [NSB:1] b_pend, b_en, b_lvl, b_ready;
   logic [31:0]  b_probe_cfg;

   irqsrc_tracker #(.NUM_SRC(NS), .NUM_CHILD(4), .MSG_MODE(1'b0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_op_i(wr_op),
      .wr_src_i(wr_src), .wr_data_i(wr_data), .probe_src_i(probe_src),
      .pend_o(pend), .en_o(en), .lvl_o(lvl), .ready_o(ready), .probe_cfg_o(probe_cfg));

   irqsrc_tracker #(.NUM_SRC(NSB), .NUM_CHILD(0), .MSG_MODE(1'b1)) dut_b (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(b_irq), .wr_en_i(b_wr_en), .wr_op_i(b_wr_op),
      .wr_src_i(b_wr_src), .wr_data_i(b_wr_data), .probe_src_i(b_probe_src),
      .pend_o(b_pend), .en_o(b_en), .lvl_o(b_lvl), .ready_o(b_ready), .probe_cfg_o(b_probe_cfg));

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [NS:1] m_pend = '0, m_en = '0, m_prev = '0, m_deleg = '0;
   logic [2:0]  m_mode  [1:NS];
   logic [9:0]  m_child [1:NS];

   function automatic logic [31:0] bswap(input logic [31:0] d);
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   function automatic logic exp_lvl(input int s);
      if (m_deleg[s]) return 1'b0;
      case (m_mode[s])
         3'd4, 3'd6: return m_prev[s];
         3'd5, 3'd7: return !m_prev[s];
         default:    return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_cfg(input int s);
      if (s < 1 || s > NS) return 32'd0;
      return {21'd0, m_deleg[s], m_child[s] | {7'd0, m_mode[s]}};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_update();
      logic [31:0] num;
      num = (wr_op == 3'd5) ? bswap(wr_data) : wr_data;
      for (int s = 1; s <= NS; s++) begin
         bit act_ok, lvl_m, hw, np, ne, tgt;
         logic [2:0] md;
         md     = m_mode[s];
         act_ok = !m_deleg[s] && (md == 3'd1 || md >= 3'd4);
         lvl_m  = !m_deleg[s] && md >= 3'd6;
         hw = 1'b0;
         if (!m_deleg[s]) begin
            case (md)
               3'd4: hw = irq[s] && !m_prev[s];
               3'd5: hw = !irq[s] && m_prev[s];
               3'd6: hw = irq[s];
               3'd7: hw = !irq[s];
               default: hw = 1'b0;
            endcase
         end
         np  = m_pend[s] | hw;
         ne  = m_en[s];
         tgt = (num == 32'(s));
         if (wr_en) begin
            if ((wr_op == 3'd1 || wr_op == 3'd5) && tgt && act_ok && !lvl_m) np = 1'b1;
            if (wr_op == 3'd2 && tgt && act_ok && !lvl_m) np = 1'b0;
            if (wr_op == 3'd3 && tgt && act_ok) ne = 1'b1;
            if (wr_op == 3'd4 && tgt && act_ok) ne = 1'b0;
            if (wr_op == 3'd0 && int'(wr_src) == s) begin
               if (wr_data[10]) begin
                  m_deleg[s] = 1'b1; m_child[s] = wr_data[9:0]; m_mode[s] = 3'd0;
               end else begin
                  m_deleg[s] = 1'b0; m_child[s] = 10'd0; m_mode[s] = wr_data[2:0];
               end
               if (wr_data[10] || wr_data[2:0] == 3'd0) begin np = 1'b0; ne = 1'b0; end
            end
         end
         m_pend[s] = np; m_en[s] = ne; m_prev[s] = irq[s];
      end
   endtask

   task automatic compare_all();
      logic [NS:1] lv;
      for (int s = 1; s <= NS; s++) lv[s] = exp_lvl(s);
      check("R5/R6/R7 pend vs model", 64'(pend), 64'(m_pend));
      check("R9 enable vs model", 64'(en), 64'(m_en));
      check("R12 ready vs model", 64'(ready), 64'(m_pend & m_en));
      check("R12 level vs model", 64'(lvl), 64'(lv));
      check("R2 probe vs model", 64'(probe_cfg), 64'(exp_cfg(int'(probe_src))));
   endtask

   task automatic step();
      model_update();
      @(posedge clk);
      #2;
      compare_all();
      wr_en = 1'b0;
      b_wr_en = 1'b0;
   endtask

   task automatic wr(input logic [2:0] op, input logic [4:0] src, input logic [31:0] d);
      wr_en = 1'b1; wr_op = op; wr_src = src; wr_data = d;
      step();
   endtask

   task automatic bwr(input logic [2:0] op, input logic [2:0] src, input logic [31:0] d);
      b_wr_en = 1'b1; b_wr_op = op; b_wr_src = src; b_wr_data = d;
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [NS:1] snap;
      int seed;
      for (int s = 1; s <= NS; s++) begin m_mode[s] = 3'd0; m_child[s] = 10'd0; end
      seed = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      // R1 reset state
      probe_src = 5'd3;
      check("R1 pend after reset", 64'(pend), 64'd0);
      check("R1 enable after reset", 64'(en), 64'd0);
      check("R1 ready/level after reset", 64'(ready | lvl), 64'd0);
      check("R1 config after reset", 64'(probe_cfg), 64'd0);

      // rising edge source 3
      wr(3'd0, 5'd3, 32'h0000_0004);
      check("R2 mode stored", 64'(probe_cfg), 64'h4);
      irq[3] = 1'b1; step();
      check("R5 rising edge sets pend", 64'(pend[3]), 64'd1);
      wr(3'd3, 5'd0, 32'd3);
      check("R9 enable set by number", 64'(en[3]), 64'd1);
      check("R12 ready when pend and en", 64'(ready[3]), 64'd1);
      check("R12 level follows input", 64'(lvl[3]), 64'd1);
      wr(3'd2, 5'd0, 32'd3);
      check("R5 edge pend cleared by sw", 64'(pend[3]), 64'd0);
      step();
      check("R5 held high is no edge", 64'(pend[3]), 64'd0);
      irq[3] = 1'b0; step();
      irq[3] = 1'b1; step();
      check("R5 second rising edge", 64'(pend[3]), 64'd1);

      // delegate source 3
      wr(3'd0, 5'd3, 32'hFFFF_F405);
      check("R2 delegated word", 64'(probe_cfg), 64'h405);
      check("R4 delegation clears pend", 64'(pend[3]), 64'd0);
      check("R4 delegation clears enable", 64'(en[3]), 64'd0);
      wr(3'd1, 5'd0, 32'd3);
      check("R7 set ignored when delegated", 64'(pend[3]), 64'd0);
      wr(3'd3, 5'd0, 32'd3);
      check("R9 enable ignored when delegated", 64'(en[3]), 64'd0);

      // level high source 4
      probe_src = 5'd4;
      irq[4] = 1'b1;
      wr(3'd0, 5'd4, 32'h0000_03F6);
      check("R2 extra bits dropped", 64'(probe_cfg), 64'h6);
      check("R6 old mode used in write cycle", 64'(pend[4]), 64'd0);
      step();
      check("R6 level high sets pend", 64'(pend[4]), 64'd1);
      wr(3'd2, 5'd0, 32'd4);
      check("R8 level clear ignored", 64'(pend[4]), 64'd1);
      irq[4] = 1'b0;
      wr(3'd0, 5'd4, 32'h0000_0000);
      check("R4 zero config clears pend", 64'(pend[4]), 64'd0);
      wr(3'd0, 5'd4, 32'h0000_0006);
      wr(3'd1, 5'd0, 32'd4);
      check("R8 direct mode level set ignored", 64'(pend[4]), 64'd0);

      // out of range numbers
      snap = pend;
      wr(3'd1, 5'd0, 32'd0);
      wr(3'd1, 5'd0, 32'd32);
      wr(3'd1, 5'd0, 32'h0900_0000);
      check("R10 bad numbers leave pend", 64'(pend), 64'(snap));

      // detached source 9 and byte swapped set
      wr(3'd0, 5'd9, 32'h0000_0001);
      irq[9] = 1'b1; step();
      irq[9] = 1'b0; step();
      check("R7 detached ignores input", 64'(pend[9]), 64'd0);
      wr(3'd5, 5'd0, 32'h0900_0000);
      check("R11 swapped number sets pend", 64'(pend[9]), 64'd1);
      wr(3'd6, 5'd0, 32'd9);
      wr(3'd2, 5'd0, 32'd9);
      check("R7 detached accepts sw clear", 64'(pend[9]), 64'd0);

      // falling edge source 5
      wr(3'd0, 5'd5, 32'h0000_0005);
      irq[5] = 1'b1; step();
      check("R12 falling level inverted", 64'(lvl[5]), 64'd0);
      check("R5 rising ignored in fall mode", 64'(pend[5]), 64'd0);
      irq[5] = 1'b0; step();
      check("R5 falling edge sets pend", 64'(pend[5]), 64'd1);

      // clear wins over edge, source 6
      wr(3'd0, 5'd6, 32'h0000_0004);
      irq[6] = 1'b1;
      wr(3'd2, 5'd0, 32'd6);
      check("R5 clear wins over edge", 64'(pend[6]), 64'd0);

      // reserved mode, source 7
      probe_src = 5'd7;
      irq[7] = 1'b1;
      wr(3'd0, 5'd7, 32'h0000_0002);
      wr(3'd1, 5'd0, 32'd7);
      check("R7 reserved mode ignores set", 64'(pend[7]), 64'd0);
      check("R2 reserved code stored", 64'(probe_cfg), 64'h2);

      // message delivery build without children
      b_probe_src = 3'd2;
      bwr(3'd0, 3'd2, 32'h0000_0403);
      check("R3 delegate without child stores zero", 64'(b_probe_cfg), 64'd0);
      bwr(3'd0, 3'd3, 32'h0000_0006);
      bwr(3'd1, 3'd0, 32'd3);
      check("R8 message mode level set accepted", 64'(b_pend[3]), 64'd1);
      bwr(3'd2, 3'd0, 32'd3);
      check("R8 message mode level clear ignored", 64'(b_pend[3]), 64'd1);
      bwr(3'd0, 3'd3, 32'h0000_0000);
      check("R4 zero config clears pend", 64'(b_pend[3]), 64'd0);

      // constrained random phase
      for (int i = 0; i < 3000; i++) begin
         irq       = irq ^ NS'($urandom & $urandom & $urandom);
         probe_src = 5'($urandom % 32);
         if (($urandom % 10) < 6) begin
            logic [2:0] op;
            logic [31:0] d;
            logic [31:0] n;
            op = 3'($urandom % 8);
            n  = 32'($urandom % 36);
            if (op == 3'd0) begin
               if (($urandom % 8) == 0) d = 32'h400 | ($urandom & 32'h3FF);
               else d = ($urandom & 32'hFFFF_FBF8) | 32'($urandom % 8);
            end else if (op == 3'd5) d = bswap(n);
            else if (($urandom % 16) == 0) d = $urandom;
            else d = n;
            wr(op, 5'($urandom % 32), d);
         end else begin
            step();
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule